// File: doc/BRIEF.md
# Halfword-Addressed Memory Access Unit

This block connects a 32-bit processor core to a RAM whose smallest addressable unit is a 16-bit halfword. Each request names a base halfword address, a 3-bit positive immediate index, an access width and, for reads, whether the result is sign- or zero-extended. From that request the unit drives the RAM address, byte-lane enables and lane-steered write data in the same cycle. On a read it aligns the returned word, extends it to 32 bits and registers it, so the result appears one clock after the request.

The RAM port is 32 bits wide and reads combinationally. Bits 15:0 hold the halfword at the presented address and bits 31:16 hold the halfword at the next address. Byte enable 0 covers bits 7:0, enable 1 covers bits 15:8, enable 2 covers bits 23:16 and enable 3 covers bits 31:24. Narrow writes use these enables, so no read-modify-write sequence is needed.

Top module: `hma_mem_access`

## Requirements
- R1: Width encoding on `req_size` is 2'b00 byte, 2'b01 halfword, 2'b10 word. For halfword and word accesses `ram_addr` = `req_base` + `req_imm`. For byte accesses `ram_addr` = `req_base` + `req_imm[2:1]` and `req_imm[0]` selects the byte: 0 is the low byte (bits 7:0) and 1 is the high byte (bits 15:8). The sum wraps modulo 2^AW.
- R2: A word write asserts `ram_be` = 4'b1111 and stores `req_wdata[15:0]` at the addressed halfword and `req_wdata[31:16]` at the next halfword.
- R3: A halfword write asserts `ram_be` = 4'b0011 and stores `req_wdata[15:0]` at the addressed halfword. Nothing else in memory changes.
- R4: A byte write asserts `ram_be` = 4'b0001 when `req_imm[0]`=0 and 4'b0010 when it is 1. It stores `req_wdata[7:0]` in the selected byte and leaves the other byte of that halfword unchanged.
- R5: A word read returns {halfword at address+1, halfword at address} on `rd_data` one clock after the request.
- R6: A halfword read returns the addressed halfword in bits 15:0. Bits 31:16 are copies of bit 15 when `req_signed`=1 and zeros when it is 0.
- R7: A byte read returns the byte chosen by `req_imm[0]` in bits 7:0. Bits 31:8 are copies of its bit 7 when `req_signed`=1 and zeros when it is 0.
- R8: `rd_valid` is 1 in exactly the cycle after an accepted read. In every other cycle it is 0 and `rd_data` keeps its last value.
- R9: Size code 2'b11 is reserved. A reserved request holds `ram_en` low, writes no memory and leaves `rd_valid` and `rd_data` unchanged.
- R10: After reset `rd_valid` is 0, `rd_data` is 0 and `ram_en` is 0 while no request is presented.
- R11: `req_signed` has no effect on word reads or on any write.
- R12: `ram_be` is 4'b0000 on reads. `ram_we` is 1 only for accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code |
| req_signed | input | 1 | Sign-extend narrow reads |
| req_base | input | AW | Base halfword address |
| req_imm | input | IMM_W | Positive immediate index |
| req_wdata | input | 32 | Write data, right-aligned |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM halfword address |
| ram_be | output | 4 | RAM byte-lane enables |
| ram_wdata | output | 32 | Lane-steered write data |
| ram_rdata | input | 32 | RAM read data for ram_addr |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Aligned, extended read result |

## Verification
The registered return of one read and the address/enable phase of the next request can fall in the same cycle. The bench provokes this by issuing requests back to back with no idle cycle: read then write, write then read of the same halfword, and read then reserved request. In each case it judges that the earlier read's data is delivered, or held, correctly while the new request's enables and address are correct. A write followed at once by a read of the same location must return the newly written bytes, which exercises the enables and the combinational RAM read together.

// File: rtl/hma_pkg.sv
package hma_pkg;
    localparam int DATA_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSV  = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_state_t;
endpackage

// File: rtl/hma_addr_gen.sv
module hma_addr_gen
    import hma_pkg::*;
#(
    parameter int AW    = 12,
    parameter int IMM_W = 3
) (
    input  logic [AW-1:0]    base,
    input  logic [IMM_W-1:0] imm,
    input  acc_size_e        size,
    output logic [AW-1:0]    addr,
    output logic             lane_hi
);
    // byte accesses count the immediate in bytes, others in halfwords
    logic [AW-1:0] off_half;
    logic [AW-1:0] off_byte;

    always_comb begin
        off_half = AW'(imm);
        off_byte = AW'(imm[IMM_W-1:1]);
        if (size == SZ_BYTE) begin
            addr    = base + off_byte;
            lane_hi = imm[0];
        end else begin
            addr    = base + off_half;
            lane_hi = 1'b0;
        end
    end
endmodule

// File: rtl/hma_wr_steer.sv
module hma_wr_steer
    import hma_pkg::*;
(
    input  acc_size_e          size,
    input  logic               lane_hi,
    input  logic [DATA_W-1:0]  wdata,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  lane_data
);
    localparam int HALF_LANES = HALF_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SUB = i % HALF_LANES;
        always_comb begin
            unique case (size)
                SZ_WORD: begin
                    be[i]                       = 1'b1;
                    lane_data[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
                end
                SZ_HALF: begin
                    be[i]                       = (i < HALF_LANES);
                    lane_data[i*LANE_W +: LANE_W] = wdata[SUB*LANE_W +: LANE_W];
                end
                SZ_BYTE: begin
                    be[i]                       = (i == int'(lane_hi));
                    lane_data[i*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
                end
                default: begin
                    be[i]                       = 1'b0;
                    lane_data[i*LANE_W +: LANE_W] = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hma_rd_align.sv
module hma_rd_align
    import hma_pkg::*;
(
    input  acc_size_e         size,
    input  logic              sext,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [HALF_W-1:0] half_v;
    logic [LANE_W-1:0] byte_v;
    logic              fill;

    always_comb begin
        half_v = rdata[HALF_W-1:0];
        byte_v = lane_hi ? rdata[2*LANE_W-1:LANE_W] : rdata[LANE_W-1:0];
        fill   = 1'b0;
        unique case (size)
            SZ_HALF: begin
                fill   = sext & half_v[HALF_W-1];
                result = {{(DATA_W-HALF_W){fill}}, half_v};
            end
            SZ_BYTE: begin
                fill   = sext & byte_v[LANE_W-1];
                result = {{(DATA_W-LANE_W){fill}}, byte_v};
            end
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/hma_mem_access.sv
module hma_mem_access
    import hma_pkg::*;
#(
    parameter int AW    = 12,
    parameter int IMM_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [AW-1:0]     req_base,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [31:0]       req_wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [3:0]        ram_be,
    output logic [31:0]       ram_wdata,
    input  logic [31:0]       ram_rdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);
    acc_size_e         size_w;
    logic              lane_hi_w;
    logic [LANES-1:0]  be_w;
    logic [DATA_W-1:0] steer_w;
    logic [DATA_W-1:0] ext_w;
    logic              acc_ok;
    logic              rd_acc;
    rd_state_t         st_d, st_q;

    assign size_w = acc_size_e'(req_size);

    hma_addr_gen #(.AW(AW), .IMM_W(IMM_W)) u_addr (
        .base    (req_base),
        .imm     (req_imm),
        .size    (size_w),
        .addr    (ram_addr),
        .lane_hi (lane_hi_w)
    );

    hma_wr_steer u_wr (
        .size      (size_w),
        .lane_hi   (lane_hi_w),
        .wdata     (req_wdata),
        .be        (be_w),
        .lane_data (steer_w)
    );

    hma_rd_align u_rd (
        .size    (size_w),
        .sext    (req_signed),
        .lane_hi (lane_hi_w),
        .rdata   (ram_rdata),
        .result  (ext_w)
    );

    always_comb begin
        acc_ok    = req_valid && (size_w != SZ_RSV);
        rd_acc    = acc_ok && !req_write;
        ram_en    = acc_ok;
        ram_we    = acc_ok && req_write;
        ram_be    = ram_we ? be_w : '0;
        ram_wdata = steer_w;
        st_d       = st_q;
        st_d.valid = rd_acc;
        if (rd_acc) begin
            st_d.data = ext_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;
endmodule

// File: rtl/hma_mem_access_chk.sv
module hma_mem_access_chk #(
    parameter int AW    = 12,
    parameter int IMM_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_size,
    input logic              req_signed,
    input logic [AW-1:0]     req_base,
    input logic [IMM_W-1:0]  req_imm,
    input logic [31:0]       req_wdata,
    input logic              ram_en,
    input logic              ram_we,
    input logic [AW-1:0]     ram_addr,
    input logic [3:0]        ram_be,
    input logic [31:0]       ram_wdata,
    input logic [31:0]       ram_rdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data
);
    logic rd_req;
    assign rd_req = req_valid && !req_write && (req_size != 2'b11);

    // R1
    wide_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && req_size != 2'b00) |-> ram_addr == AW'(req_base + AW'(req_imm)));

    // R2
    word_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && req_size == 2'b10) |-> (ram_be == 4'b1111 && ram_wdata == req_wdata));

    // R3
    half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && req_size == 2'b01) |-> (ram_be == 4'b0011 && ram_wdata[15:0] == req_wdata[15:0]));

    // R4
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && req_size == 2'b00) |-> ($countones(ram_be) == 1 && ram_be[3:2] == 2'b00));

    // R8
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && $stable(rd_data)));

    // R9
    rsv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b11) |-> (!ram_en && !ram_we));

    // R12
    rd_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |-> ram_be == 4'b0000);
endmodule

bind hma_mem_access hma_mem_access_chk #(.AW(AW), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/hma_mem_access_tb.sv
module hma_mem_access_tb;
    localparam int AW = 4;
    localparam int IW = 3;
    localparam int NH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic          req_signed = 1'b0;
    logic [AW-1:0] req_base = '0;
    logic [IW-1:0] req_imm = '0;
    logic [31:0]   req_wdata = '0;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [3:0]    ram_be;
    logic [31:0]   ram_wdata, ram_rdata;
    logic          rd_valid;
    logic [31:0]   rd_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [NH];
    logic [15:0] ref_mem [NH];
    logic [31:0] last_rd = '0;

    always #5 clk = ~clk;

    hma_mem_access #(.AW(AW), .IMM_W(IW)) u_dut (.*);

    assign ram_rdata = {mem[ram_addr + AW'(1)], mem[ram_addr]};

    always @(posedge clk) begin
        if (ram_en && ram_we) begin
            if (ram_be[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
            if (ram_be[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
            if (ram_be[2]) mem[ram_addr + AW'(1)][7:0]  <= ram_wdata[23:16];
            if (ram_be[3]) mem[ram_addr + AW'(1)][15:8] <= ram_wdata[31:24];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request cycle; checks the RAM side and then the registered result
    task automatic access(input bit wr, input logic [1:0] sz, input bit sg,
                          input logic [AW-1:0] base, input logic [IW-1:0] imm,
                          input logic [31:0] wd);
        logic [AW-1:0] a, a1;
        logic          hi;
        logic [15:0]   h0, h1;
        logic [7:0]    b;
        logic [31:0]   exp_rd;
        logic [3:0]    exp_be;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
        req_base = base; req_imm = imm; req_wdata = wd;
        hi = (sz == 2'b00) ? imm[0] : 1'b0;
        a  = (sz == 2'b00) ? base + AW'(imm >> 1) : base + AW'(imm);
        a1 = a + AW'(1);
        h0 = ref_mem[a]; h1 = ref_mem[a1];
        b  = hi ? h0[15:8] : h0[7:0];
        case (sz)
            2'b10: begin exp_rd = {h1, h0}; exp_be = 4'b1111; end
            2'b01: begin exp_rd = {{16{sg & h0[15]}}, h0}; exp_be = 4'b0011; end
            2'b00: begin exp_rd = {{24{sg & b[7]}}, b}; exp_be = hi ? 4'b0010 : 4'b0001; end
            default: begin exp_rd = last_rd; exp_be = 4'b0000; end
        endcase
        #1;
        if (sz == 2'b11) begin
            chk("R9 reserved ram_en", {31'b0, ram_en}, 32'd0);
            chk("R9 reserved ram_we", {31'b0, ram_we}, 32'd0);
        end else begin
            chk("R1 ram_addr", {28'b0, ram_addr}, {28'b0, a});
            chk("R12 ram_we", {31'b0, ram_we}, {31'b0, wr});
            chk(wr ? "R2 R3 R4 ram_be" : "R12 read ram_be", {28'b0, ram_be},
                wr ? {28'b0, exp_be} : 32'd0);
        end
        @(posedge clk);
        if (wr && sz != 2'b11) begin
            case (sz)
                2'b10: begin ref_mem[a] = wd[15:0]; ref_mem[a1] = wd[31:16]; end
                2'b01: ref_mem[a] = wd[15:0];
                default: if (hi) ref_mem[a][15:8] = wd[7:0]; else ref_mem[a][7:0] = wd[7:0];
            endcase
        end
        #2;
        if (!wr && sz != 2'b11) begin
            chk("R8 rd_valid after read", {31'b0, rd_valid}, 32'd1);
            chk(sz == 2'b10 ? "R5 R11 word read" : (sz == 2'b01 ? "R6 half read" : "R7 byte read"),
                rd_data, exp_rd);
            last_rd = exp_rd;
        end else begin
            chk("R8 R9 rd_valid low", {31'b0, rd_valid}, 32'd0);
            chk("R8 R9 rd_data held", rd_data, last_rd);
        end
        req_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R10 R12 idle ram_en", {31'b0, ram_en}, 32'd0);
        @(posedge clk);
        #2;
        chk("R8 idle rd_valid", {31'b0, rd_valid}, 32'd0);
        chk("R8 idle rd_data held", rd_data, last_rd);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R10 reset rd_valid", {31'b0, rd_valid}, 32'd0);
        chk("R10 reset rd_data", rd_data, 32'd0);
        chk("R10 reset ram_en", {31'b0, ram_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R2: fill all halfwords with word writes (req_signed set: R11)
        for (int k = 0; k < NH / 2; k++)
            access(1'b1, 2'b10, k[0], AW'(2 * k), '0, 32'h9E37_79B9 * (k + 1));

        // R5 R6 R7 R1: read sweep including address wrap
        foreach (ref_mem[i]) begin end
        for (int bi = 0; bi < 4; bi++) begin
            for (int im = 0; im < 8; im++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int sg = 0; sg < 2; sg++) begin
                        access(1'b0, 2'(sz), sg[0], AW'(bi == 0 ? 0 : (bi == 1 ? 5 : (bi == 2 ? 13 : 15))),
                               IW'(im), 32'hDEAD_BEEF);
                    end
                end
            end
        end

        // R3: halfword writes, read back both extensions
        for (int im = 0; im < 8; im++) begin
            access(1'b1, 2'b01, im[0], AW'(6), IW'(im), {16'hA5A5, 16'(16'h7F01 + im * 16'h2111)});
            access(1'b0, 2'b01, 1'b1, AW'(6), IW'(im), '0);
            access(1'b0, 2'b01, 1'b0, AW'(6), IW'(im), '0);
            access(1'b0, 2'b10, 1'b0, AW'(5), IW'(im), '0);
        end

        // R4: byte writes, neighbour byte must survive
        for (int im = 0; im < 8; im++) begin
            access(1'b1, 2'b00, im[1], AW'(9), IW'(im), {24'hFFFF_FF, 8'(8'h3C + im * 8'h29)});
            access(1'b0, 2'b10, 1'b0, AW'(9 + im / 2), '0, '0);
            access(1'b0, 2'b00, 1'b1, AW'(9), IW'(im), '0);
        end

        // R9: reserved size as read and write, then memory unchanged
        access(1'b0, 2'b10, 1'b0, AW'(3), '0, '0);
        access(1'b0, 2'b11, 1'b1, AW'(3), '0, '0);
        access(1'b1, 2'b11, 1'b0, AW'(3), '0, 32'h1234_5678);
        access(1'b0, 2'b10, 1'b0, AW'(3), '0, '0);

        // back to back: read then write, write then read same halfword
        access(1'b0, 2'b00, 1'b1, AW'(1), 3'd1, '0);
        access(1'b1, 2'b00, 1'b0, AW'(1), 3'd1, 32'h0000_0081);
        access(1'b0, 2'b00, 1'b1, AW'(1), 3'd1, '0);
        access(1'b0, 2'b00, 1'b0, AW'(1), 3'd1, '0);
        access(1'b1, 2'b10, 1'b1, AW'(15), '0, 32'h8001_7FFE);
        access(1'b0, 2'b10, 1'b1, AW'(15), '0, '0);
        access(1'b0, 2'b01, 1'b1, AW'(0), '0, '0);
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule